// File: doc/BRIEF.md
# Serial Port Host Control Interface

This block is the processor-facing control section of a programmable serial port. It decodes an 8-bit host bus with an active-low chip select, active-low read and write strobes and a select line. The select line chooses between the data path and the control/status path. The serial shift logic is outside the block: this block only hands it a loaded character, enable levels and one-cycle strobes, and it takes back ready, empty and error indications.

A single control address carries two kinds of word. After reset, or after a command that asks for an internal reset, the next control write is stored as the mode word. Every later control write is a command. Command bits drive the transmit and receive enables, the break request, the active-low terminal-ready and request-to-send outputs, and one-cycle strobes for error clearing and for entering hunt.

Data writes load the transmit holding register and pulse a load strobe. Data reads return the receiver's character and pulse an acknowledge. Control reads return a status byte built from the sticky error flags, the transmitter and receiver flags, the break indication and the data-set-ready input.

Top module: `serial_host_ctrl`

## Requirements
- R1: While `rst` is high, and after it falls, the sequencer expects a mode word. The stored command is zero, so `dtrN`=1, `rtsN`=1, `txEnable`=0, `rxEnable`=0 and `sendBreak`=0. The mode word reads 0 and all error flags are clear.
- R2: An access starts on the first clock edge at which `csN`=0 and `wrN`=0. The first control write (`ctlSel`=1) while the sequencer expects a mode word is copied to `modeWord`. It leaves the command outputs unchanged, and every later control write is a command.
- R3: A command sets the outputs from these bits: bit 0 sets `txEnable`, bit 1 drives `dtrN` low, bit 2 sets `rxEnable`, bit 3 sets `sendBreak` and bit 5 drives `rtsN` low. These levels hold until the next command, and `modeWord` does not change.
- R4: A command with bit 4 set gives a one-cycle `errClear` pulse and clears the three error flags. If an error set pulse arrives on the same edge, the clear wins.
- R5: A command with bit 6 set clears the stored command, so all command outputs become inactive. It ignores its other bits, and the next control write is taken as a mode word.
- R6: A command with bit 7 set gives a one-cycle `huntStrobe` pulse.
- R7: A data write (`ctlSel`=0) copies `dataIn` to `txHoldData` and gives exactly one one-cycle `txLoad` pulse per access, however long the strobe is held.
- R8: A data read (`csN`=0, `rdN`=0, `wrN`=1, `ctlSel`=0) drives `rxData` on `dataOut` while the access lasts. It gives exactly one one-cycle `rxAck` pulse per access.
- R9: A control read drives a status byte on `dataOut`. Its bits, from bit 0 to bit 7, are: `txReady`, `rxReady`, `txEmpty`, parity error, overrun error, framing error, `breakDet`, and the inverse of `dsrN`.
- R10: The error flags are sticky. A high on `parErrSet`, `ovrErrSet` or `frmErrSet` at a clock edge sets status bit 3, 4 or 5, and the bit stays set until R4 clears it or reset.
- R11: With `csN` high, the strobes are ignored. No register changes, no pulse is produced and `dataOut` stays 0.
- R12: When no read is active, `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| ctlSel | input | 1 | 1 = control/status, 0 = data |
| dataIn | input | 8 | Host write data |
| dataOut | output | 8 | Host read data, 0 when not reading |
| rxData | input | 8 | Character from the receiver |
| txReady | input | 1 | Transmitter can accept a character |
| rxReady | input | 1 | Receiver holds a character |
| txEmpty | input | 1 | Transmitter has nothing to send |
| breakDet | input | 1 | Break detected on the line |
| parErrSet | input | 1 | Parity error pulse |
| ovrErrSet | input | 1 | Overrun error pulse |
| frmErrSet | input | 1 | Framing error pulse |
| dsrN | input | 1 | Data-set-ready, active low |
| modeWord | output | 8 | Stored mode word |
| txHoldData | output | 8 | Transmit holding register |
| txLoad | output | 1 | One-cycle pulse: new transmit character |
| rxAck | output | 1 | One-cycle pulse: receive buffer read |
| txEnable | output | 1 | Transmitter enable |
| rxEnable | output | 1 | Receiver enable |
| sendBreak | output | 1 | Force a break on the line |
| errClear | output | 1 | One-cycle error reset pulse |
| huntStrobe | output | 1 | One-cycle enter-hunt pulse |
| dtrN | output | 1 | Terminal ready, active low |
| rtsN | output | 1 | Request to send, active low |

## Verification
A wrong sequencer state shows up at the next control write. If that word is stored as a mode when it should be a command, `modeWord` changes and the modem outputs do not; the reverse error shows the opposite. Either shows one cycle after the access starts. A lost or stuck error flag can only be seen at the next status read, so the flags are read back after each injection and after each clear. A strobe that is missing or repeated shows up as a wrong pulse count over an access held for several cycles.

// File: rtl/shc_pkg.sv
package shc_pkg;
  localparam int DW = 8;

  // command bit positions (decoded by neighbours)
  localparam int CMD_TXEN  = 0;
  localparam int CMD_DTR   = 1;
  localparam int CMD_RXEN  = 2;
  localparam int CMD_BRK   = 3;
  localparam int CMD_ERST  = 4;
  localparam int CMD_RTS   = 5;
  localparam int CMD_IRST  = 6;
  localparam int CMD_HUNT  = 7;

  // bits kept as levels in the command register
  localparam logic [DW-1:0] CMD_LEVEL_MASK =
    DW'((1 << CMD_TXEN) | (1 << CMD_DTR) | (1 << CMD_RXEN) |
        (1 << CMD_BRK) | (1 << CMD_RTS));

  typedef enum logic {SEQ_MODE, SEQ_CMD} seqState_t;

  typedef struct packed {
    logic wrDataStart;
    logic rdDataStart;
    logic errClrNow;
    logic rdCtlLevel;
    logic rdDataLevel;
  } hostStrobes_t;
endpackage

// File: rtl/shc_control.sv
module shc_control
  import shc_pkg::*;
#(
  parameter int W = DW
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         csN,
  input  logic         rdN,
  input  logic         wrN,
  input  logic         ctlSel,
  input  logic [W-1:0] dataIn,
  output hostStrobes_t strobes,
  output logic [W-1:0] modeWord,
  output logic         txEnable,
  output logic         rxEnable,
  output logic         sendBreak,
  output logic         dtrN,
  output logic         rtsN,
  output logic         errClear,
  output logic         huntStrobe
);
  localparam logic [W-1:0] LEVEL_MASK = W'(CMD_LEVEL_MASK);

  seqState_t   seqState;
  logic [W-1:0] cmdReg;
  logic wrActive, rdActive, wrPrev, rdPrev;
  logic wrStart, rdStart, ctlWrStart, cmdWrite;

  assign wrActive   = ~csN & ~wrN;
  assign rdActive   = ~csN & ~rdN & wrN;
  assign wrStart    = wrActive & ~wrPrev;
  assign rdStart    = rdActive & ~rdPrev;
  assign ctlWrStart = wrStart & ctlSel;
  assign cmdWrite   = ctlWrStart && (seqState == SEQ_CMD) && !dataIn[CMD_IRST];

  always_comb begin
    strobes.wrDataStart = wrStart & ~ctlSel;
    strobes.rdDataStart = rdStart & ~ctlSel;
    strobes.errClrNow   = cmdWrite & dataIn[CMD_ERST];
    strobes.rdCtlLevel  = rdActive & ctlSel;
    strobes.rdDataLevel = rdActive & ~ctlSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPrev <= 1'b0;
      rdPrev <= 1'b0;
    end else begin
      wrPrev <= wrActive;
      rdPrev <= rdActive;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seqState   <= SEQ_MODE;
      modeWord   <= '0;
      cmdReg     <= '0;
      errClear   <= 1'b0;
      huntStrobe <= 1'b0;
    end else begin
      errClear   <= 1'b0;
      huntStrobe <= 1'b0;
      if (ctlWrStart) begin
        if (seqState == SEQ_MODE) begin
          modeWord <= dataIn;
          seqState <= SEQ_CMD;
        end else if (dataIn[CMD_IRST]) begin
          cmdReg   <= '0;
          seqState <= SEQ_MODE;
        end else begin
          cmdReg     <= dataIn & LEVEL_MASK;
          errClear   <= dataIn[CMD_ERST];
          huntStrobe <= dataIn[CMD_HUNT];
        end
      end
    end
  end

  assign txEnable  = cmdReg[CMD_TXEN];
  assign rxEnable  = cmdReg[CMD_RXEN];
  assign sendBreak = cmdReg[CMD_BRK];
  assign dtrN      = ~cmdReg[CMD_DTR];
  assign rtsN      = ~cmdReg[CMD_RTS];
endmodule

// File: rtl/shc_datapath.sv
module shc_datapath
  import shc_pkg::*;
#(
  parameter int W = DW,
  parameter int NERR = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  hostStrobes_t  strobes,
  input  logic [W-1:0]  dataIn,
  input  logic [W-1:0]  rxData,
  input  logic          txReady,
  input  logic          rxReady,
  input  logic          txEmpty,
  input  logic          breakDet,
  input  logic [NERR-1:0] errSet,
  input  logic          dsrN,
  output logic [W-1:0]  txHoldData,
  output logic          txLoad,
  output logic          rxAck,
  output logic [W-1:0]  statusByte,
  output logic [W-1:0]  dataOut
);
  logic [NERR-1:0] errFlags;

  always_ff @(posedge clk) begin
    if (rst) begin
      txHoldData <= '0;
      txLoad     <= 1'b0;
      rxAck      <= 1'b0;
    end else begin
      txLoad <= strobes.wrDataStart;
      rxAck  <= strobes.rdDataStart;
      if (strobes.wrDataStart) txHoldData <= dataIn;
    end
  end

  for (genvar i = 0; i < NERR; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst || strobes.errClrNow) errFlags[i] <= 1'b0;
      else if (errSet[i])           errFlags[i] <= 1'b1;
    end
  end

  always_comb begin
    statusByte = '0;
    statusByte[0] = txReady;
    statusByte[1] = rxReady;
    statusByte[2] = txEmpty;
    statusByte[3 +: NERR] = errFlags;
    statusByte[6] = breakDet;
    statusByte[7] = ~dsrN;
  end

  always_comb begin
    if (strobes.rdCtlLevel)       dataOut = statusByte;
    else if (strobes.rdDataLevel) dataOut = rxData;
    else                          dataOut = '0;
  end
endmodule

// File: rtl/serial_host_ctrl.sv
module serial_host_ctrl
  import shc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       ctlSel,
  input  logic [7:0] dataIn,
  output logic [7:0] dataOut,
  input  logic [7:0] rxData,
  input  logic       txReady,
  input  logic       rxReady,
  input  logic       txEmpty,
  input  logic       breakDet,
  input  logic       parErrSet,
  input  logic       ovrErrSet,
  input  logic       frmErrSet,
  input  logic       dsrN,
  output logic [7:0] modeWord,
  output logic [7:0] txHoldData,
  output logic       txLoad,
  output logic       rxAck,
  output logic       txEnable,
  output logic       rxEnable,
  output logic       sendBreak,
  output logic       errClear,
  output logic       huntStrobe,
  output logic       dtrN,
  output logic       rtsN
);
  hostStrobes_t strobes;
  logic [7:0]   statusByte;

  shc_control #(.W(8)) u_control (
    .clk(clk), .rst(rst), .csN(csN), .rdN(rdN), .wrN(wrN),
    .ctlSel(ctlSel), .dataIn(dataIn), .strobes(strobes),
    .modeWord(modeWord), .txEnable(txEnable), .rxEnable(rxEnable),
    .sendBreak(sendBreak), .dtrN(dtrN), .rtsN(rtsN),
    .errClear(errClear), .huntStrobe(huntStrobe)
  );

  shc_datapath #(.W(8), .NERR(3)) u_datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .dataIn(dataIn),
    .rxData(rxData), .txReady(txReady), .rxReady(rxReady),
    .txEmpty(txEmpty), .breakDet(breakDet),
    .errSet({frmErrSet, ovrErrSet, parErrSet}), .dsrN(dsrN),
    .txHoldData(txHoldData), .txLoad(txLoad), .rxAck(rxAck),
    .statusByte(statusByte), .dataOut(dataOut)
  );
endmodule

// File: rtl/shc_checker.sv
module shc_checker (
  input logic       clk,
  input logic       rst,
  input logic       csN,
  input logic       rdN,
  input logic       txLoad,
  input logic       rxAck,
  input logic       errClear,
  input logic       huntStrobe,
  input logic [7:0] statusByte,
  input logic [7:0] dataOut,
  input logic       dtrN,
  input logic       rtsN,
  input logic       txEnable,
  input logic       rxEnable
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (dtrN && rtsN && !txEnable && !rxEnable && statusByte[5:3] == 3'b000));

  // R4
  err_clear_chk: assert property (@(posedge clk) disable iff (rst)
    errClear |-> statusByte[5:3] == 3'b000);

  // R4
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    errClear |=> !errClear);

  // R6
  hunt_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    huntStrobe |=> !huntStrobe);

  // R7
  tx_load_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    txLoad |=> !txLoad);

  // R8
  rx_ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rxAck |=> !rxAck);

  // R11
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    csN |=> (!txLoad && !rxAck && !errClear && !huntStrobe));

  // R12
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (csN || rdN) |-> dataOut == 8'h00);
endmodule

bind serial_host_ctrl shc_checker u_chk (.*);

// File: tb/serial_host_ctrl_bench.sv
module serial_host_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csN = 1'b1, rdN = 1'b1, wrN = 1'b1, ctlSel = 1'b0;
  logic [7:0] dataIn = '0, rxData = '0;
  logic txReady = 0, rxReady = 0, txEmpty = 0, breakDet = 0;
  logic parErrSet = 0, ovrErrSet = 0, frmErrSet = 0, dsrN = 1;
  logic [7:0] dataOut, modeWord, txHoldData;
  logic txLoad, rxAck, txEnable, rxEnable, sendBreak, errClear, huntStrobe, dtrN, rtsN;

  always #2 clk = ~clk;

  serial_host_ctrl u_serial_host_ctrl (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // bench model
  logic [7:0] expMode = 0, expCmd = 0, expHold = 0;
  logic [2:0] expErr = 0;
  bit expSeqMode = 1;
  int nTxLoad, nRxAck, nErrClr, nHunt;

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus();
    return {~dsrN, breakDet, expErr, txEmpty, rxReady, txReady};
  endfunction

  task automatic countPulses();
    nTxLoad += int'(txLoad); nRxAck += int'(rxAck);
    nErrClr += int'(errClear); nHunt += int'(huntStrobe);
  endtask

  task automatic clearCounts();
    nTxLoad = 0; nRxAck = 0; nErrClr = 0; nHunt = 0;
  endtask

  task automatic checkOutputs(input string req);
    chk(modeWord == expMode, {req, " mode"}, modeWord, expMode);
    chk(txEnable == expCmd[0] && ~dtrN == expCmd[1] && rxEnable == expCmd[2] &&
        sendBreak == expCmd[3] && ~rtsN == expCmd[5], {req, " cmd outputs"},
        {2'b0, ~rtsN, 1'b0, sendBreak, rxEnable, ~dtrN, txEnable}, expCmd & 8'h2F);
    chk(txHoldData == expHold, {req, " hold"}, txHoldData, expHold);
  endtask

  // write access, strobe held for hold cycles; optional error pulses on first edge
  task automatic hostWrite(input bit ctl, input logic [7:0] d, input int hold, input logic [2:0] errIn);
    bit isCmd, errRst, hunt;
    @(negedge clk);
    csN = 0; wrN = 0; ctlSel = ctl; dataIn = d;
    {frmErrSet, ovrErrSet, parErrSet} = errIn;
    clearCounts();
    @(negedge clk);
    {frmErrSet, ovrErrSet, parErrSet} = 3'b000;
    countPulses();
    for (int i = 1; i < hold; i++) begin @(negedge clk); countPulses(); end
    csN = 1; wrN = 1;
    @(negedge clk); countPulses();
    // model
    isCmd = 0; errRst = 0; hunt = 0;
    expErr |= errIn;
    if (!ctl) expHold = d;
    else if (expSeqMode) begin expMode = d; expSeqMode = 0; end
    else if (d[6]) begin expCmd = 0; expSeqMode = 1; end
    else begin
      isCmd = 1; expCmd = d & 8'h2F; errRst = d[4]; hunt = d[7];
      if (d[4]) expErr = 0;
    end
    if (ctl) begin
      chk(nErrClr == int'(errRst), "R4 errClear pulses", 8'(nErrClr), 8'(errRst));
      chk(nHunt == int'(hunt), "R6 huntStrobe pulses", 8'(nHunt), 8'(hunt));
      checkOutputs(isCmd ? "R3" : (expSeqMode ? "R5" : "R2"));
    end else begin
      chk(nTxLoad == 1, "R7 txLoad pulses", 8'(nTxLoad), 8'd1);
      checkOutputs("R7");
    end
  endtask

  task automatic hostRead(input bit ctl, input int hold, output logic [7:0] v);
    @(negedge clk);
    csN = 0; rdN = 0; ctlSel = ctl;
    clearCounts();
    #1 v = dataOut;
    @(negedge clk); countPulses();
    for (int i = 1; i < hold; i++) begin @(negedge clk); countPulses(); end
    csN = 1; rdN = 1;
    @(negedge clk); countPulses();
    chk(nRxAck == (ctl ? 0 : 1), "R8 rxAck pulses", 8'(nRxAck), ctl ? 8'd0 : 8'd1);
    chk(dataOut == 8'h00, "R12 idle dataOut", dataOut, 8'h00);
  endtask

  task automatic readStatus(input string req);
    logic [7:0] v;
    hostRead(1, 1, v);
    chk(v == expStatus(), req, v, expStatus());
  endtask

  task automatic injectErr(input logic [2:0] e);
    @(negedge clk);
    {frmErrSet, ovrErrSet, parErrSet} = e;
    @(negedge clk);
    {frmErrSet, ovrErrSet, parErrSet} = 3'b000;
    expErr |= e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(dtrN && rtsN && !txEnable && !rxEnable && !sendBreak, "R1 reset outputs",
        {rtsN, dtrN, sendBreak, rxEnable, txEnable}, 8'h18);
    chk(dataOut == 8'h00, "R12 reset dataOut", dataOut, 8'h00);
    rst = 0;
    @(negedge clk);
    chk(modeWord == 8'h00, "R1 mode after reset", modeWord, 8'h00);
    readStatus("R1 status after reset");

    // R2 first control write is the mode
    hostWrite(1, 8'hFE, 1, 3'b000);
    // R3 command
    hostWrite(1, 8'h27, 1, 3'b000);
    // R10 sticky errors, then R4 clear
    injectErr(3'b101);
    readStatus("R10 sticky flags");
    injectErr(3'b010);
    readStatus("R10 flags accumulate");
    hostWrite(1, 8'h10, 1, 3'b000);
    readStatus("R4 flags cleared");
    // R4 clear wins over a set on the same edge
    hostWrite(1, 8'h12, 1, 3'b111);
    expErr = 3'b000;
    readStatus("R4 clear beats set");
    // R6 hunt
    hostWrite(1, 8'h80, 3, 3'b000);
    // R5 internal reset then mode
    hostWrite(1, 8'h2F, 1, 3'b000);
    hostWrite(1, 8'h7F, 1, 3'b000);
    hostWrite(1, 8'hA5, 1, 3'b000);
    // R7 long held data write
    hostWrite(0, 8'h3C, 5, 3'b000);
    // R8 data read held
    rxData = 8'hC3;
    hostRead(0, 4, v);
    chk(v == 8'hC3, "R8 data read", v, 8'hC3);
    // R9 status layout
    txReady = 1; rxReady = 0; txEmpty = 1; breakDet = 1; dsrN = 0;
    readStatus("R9 status layout");
    // R11 deselected strobes
    @(negedge clk);
    csN = 1; wrN = 0; rdN = 1; ctlSel = 1; dataIn = 8'h40;
    clearCounts();
    repeat (3) begin @(negedge clk); countPulses(); end
    chk(dataOut == 8'h00, "R11 dataOut deselected", dataOut, 8'h00);
    wrN = 1; rdN = 0; ctlSel = 0;
    repeat (3) begin @(negedge clk); countPulses(); end
    chk(dataOut == 8'h00, "R11 read deselected", dataOut, 8'h00);
    rdN = 1;
    chk(nTxLoad + nRxAck + nErrClr + nHunt == 0, "R11 no pulses",
        8'(nTxLoad + nRxAck + nErrClr + nHunt), 8'h00);
    checkOutputs("R11");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 4));
      case (op)
        0: hostWrite(0, 8'($urandom), int'($urandom_range(1, 3)), 3'b000);
        1: begin
          logic [7:0] d;
          d = 8'($urandom);
          if ($urandom_range(0, 3) != 0) d[6] = 1'b0;
          hostWrite(1, d, int'($urandom_range(1, 3)), 3'($urandom));
        end
        2: begin
          logic [7:0] r;
          r = 8'($urandom);
          rxData = r;
          hostRead(0, int'($urandom_range(1, 3)), v);
          chk(v == r, "R8 random data read", v, r);
        end
        3: begin
          {txReady, rxReady, txEmpty, breakDet, dsrN} = 5'($urandom);
          readStatus("R9 random status");
        end
        default: begin
          injectErr(3'($urandom));
          readStatus("R10 random flags");
        end
      endcase
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule